// File: doc/BRIEF.md
# Capture Compare Channel Unit

This block pairs an up-counting time base with a small set of channels. Each channel can either record the time at which its input pin changes, or act when the time base reaches a programmed value. The time base advances once every 2^(3+I) system clocks, where I is a 3-bit rate select. When it passes its all-ones value it restarts from a programmable reload value rather than from zero, so the reload value sets the period.

In capture mode a channel stores the time base value when a chosen edge arrives on its pin, and raises its interrupt flag. In compare mode a channel watches for the time base to equal its stored value. On a match it raises its flag, toggles its output latch, or does both. Software may rewrite a compare value while the time base is running. Switching a channel between two values on each match gives a pulse train without stopping the counter. All settings and values go through a simple word-wide write/read register port. The interrupt flags leave the block as level outputs and are cleared by a per-channel clear input.

Top module: `capcom_unit`

## Requirements
- R1: After reset the time base, reload value, control word, mode word and every channel value read as zero. Every interrupt flag, output latch and output enable is low.
- R2: The register map is as follows. Control at address 0 holds the run bit in bit 0 and the rate select I in bits 3:1. Reload is at address 1 and the time base at address 2. The mode word at address 3 holds channel k in bits 4k+3:4k. Channel k's value is at address 4+k. A written value reads back at the same address.
- R3: While run is 1 the time base increments once every 2^(3+I) clocks, counted from the write that sets run. While run is 0 it holds its value.
- R4: On a step taken from 0xFFFF the time base loads the reload value. Every other step adds one.
- R5: Mode nibble encoding: bit 3 = 1 disables the channel. Bit 2 = 0 selects capture, with bit 0 enabling rising edges and bit 1 enabling falling edges. A pin change on an enabled edge stores the time base value in the channel register on the third clock edge after the pin is sampled, and sets the channel's flag in the same edge.
- R6: A pin edge of a kind the mode does not enable leaves the channel register and flag unchanged. A disabled channel (bit 3 = 1) captures nothing.
- R7: Bit 2 = 1 selects compare, with bit 0 enabling the flag and bit 1 enabling the output toggle. One clock after the time base steps to a value equal to the channel register, the enabled actions take effect.
- R8: A compare match acts only once per time base value, however many clocks that value is held.
- R9: A compare value rewritten while running takes effect for the next step. A match then happens when the time base reaches the new value.
- R10: The output enable of a channel is high only in compare modes. It is low in capture modes and when the channel is disabled.
- R11: The clear input drops a flag. When a flag-setting event and the clear fall in the same cycle, the flag ends set. When a capture and a software write to the same channel register fall in the same cycle, the captured value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | CNT_W | Register read data (combinational) |
| pin_in | input | NUM_CH | Channel input pins |
| pin_out | output | NUM_CH | Channel output latches |
| pin_oe | output | NUM_CH | Channel output enables |
| irq_clr | input | NUM_CH | Per-channel flag clear |
| irq_flag | output | NUM_CH | Per-channel interrupt flags |

## Verification
Two events can land in the same clock edge. A hardware capture can coincide with a software write to the same channel register, and the flag set by that capture can coincide with a software clear of the flag. The bench stops the time base at a known value and raises a pin. It then places the register write and the clear on the exact edge at which the capture lands, which is the third edge after the pin change. It judges the outcome by reading back the captured time value and seeing the flag still high. A second pass with no capture pending confirms that the same write is accepted.

// File: rtl/capcom_pkg.sv
package capcom_pkg;

   localparam int MODE_W     = 4;
   localparam int ADDR_CTRL  = 0;
   localparam int ADDR_RELD  = 1;
   localparam int ADDR_TIME  = 2;
   localparam int ADDR_MODE  = 3;
   localparam int ADDR_CHAN  = 4;

   typedef struct packed {
      logic is_cap;
      logic is_cmp;
      logic cap_rise;
      logic cap_fall;
      logic cmp_irq;
      logic cmp_tog;
   } chan_ctl_t;

   function automatic chan_ctl_t decode_mode(input logic [MODE_W-1:0] m);
      chan_ctl_t c;
      c.is_cap   = !m[3] && !m[2];
      c.is_cmp   = !m[3] &&  m[2];
      c.cap_rise = !m[3] && !m[2] && m[0];
      c.cap_fall = !m[3] && !m[2] && m[1];
      c.cmp_irq  = !m[3] &&  m[2] && m[0];
      c.cmp_tog  = !m[3] &&  m[2] && m[1];
      return c;
   endfunction

endpackage

// File: rtl/capcom_prescaler.sv
module capcom_prescaler #(
   parameter int SEL_W      = 3,
   parameter int BASE_SHIFT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int DIV_W = BASE_SHIFT + (1 << SEL_W) - 1;

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("capcom_prescaler: SEL_W out of range");
   end
   if (BASE_SHIFT < 1) begin : g_bad_shift
      $error("capcom_prescaler: BASE_SHIFT must be at least 1");
   end

   logic [DIV_W-1:0] div_cnt;
   logic [DIV_W-1:0] div_lim;

   always_comb begin
      div_lim = DIV_W'((64'd1 << (BASE_SHIFT + 32'(sel))) - 64'd1);
      tick    = run && (div_cnt == div_lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            div_cnt <= '0;
      else if (!run || tick) div_cnt <= '0;
      else                   div_cnt <= div_cnt + 1'b1;
   end

   // R3: a tick is never followed by another tick on the next clock
   p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R3: a stopped divider produces no tick
   p_no_tick_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick);

endmodule

// File: rtl/capcom_timebase.sv
module capcom_timebase #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_time,
   input  logic             wr_reload,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] tb_value,
   output logic [CNT_W-1:0] reload,
   output logic             stepped
);
   if (CNT_W < 4) begin : g_bad_width
      $error("capcom_timebase: CNT_W too small");
   end

   logic at_top;
   assign at_top = &tb_value;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tb_value <= '0;
         reload   <= '0;
         stepped  <= 1'b0;
      end else begin
         if (wr_reload) reload <= wdata;
         if (wr_time)    tb_value <= wdata;
         else if (tick)  tb_value <= at_top ? reload : tb_value + 1'b1;
         stepped <= tick && !wr_time;
      end
   end

   // R4: stepping from all ones restarts from the reload value
   p_wrap_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_time && at_top) |=> (tb_value == $past(reload)));

   // R4: any other step adds one
   p_step_plus_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_time && !at_top) |=> (tb_value == $past(tb_value) + 1'b1));

   // R3: without a tick or a write the value is held
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_time) |=> $stable(tb_value));

endmodule

// File: rtl/capcom_channel.sv
module capcom_channel
   import capcom_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode,
   input  logic [CNT_W-1:0]  tb_value,
   input  logic              stepped,
   input  logic              pin_in,
   input  logic              wr_cc,
   input  logic [CNT_W-1:0]  wdata,
   input  logic              irq_clr,
   output logic [CNT_W-1:0]  cc_value,
   output logic              irq,
   output logic              pin_out,
   output logic              pin_oe
);
   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("capcom_channel: SYNC_STAGES out of range");
   end

   chan_ctl_t ctl;
   logic [SYNC_STAGES:0] pin_pipe;
   logic pin_now, pin_prev;
   logic edge_up, edge_dn;
   logic cap_evt, match, irq_set, tog;

   always_comb begin
      ctl      = decode_mode(mode);
      pin_now  = pin_pipe[SYNC_STAGES-1];
      pin_prev = pin_pipe[SYNC_STAGES];
      edge_up  = pin_now && !pin_prev;
      edge_dn  = !pin_now && pin_prev;
      cap_evt  = (ctl.cap_rise && edge_up) || (ctl.cap_fall && edge_dn);
      match    = ctl.is_cmp && stepped && (tb_value == cc_value);
      irq_set  = cap_evt || (match && ctl.cmp_irq);
      tog      = match && ctl.cmp_tog;
      pin_oe   = ctl.is_cmp;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_pipe <= '0;
         cc_value <= '0;
         irq      <= 1'b0;
         pin_out  <= 1'b0;
      end else begin
         pin_pipe <= {pin_pipe[SYNC_STAGES-1:0], pin_in};
         if (cap_evt)    cc_value <= tb_value;
         else if (wr_cc) cc_value <= wdata;
         if (irq_set)      irq <= 1'b1;
         else if (irq_clr) irq <= 1'b0;
         if (tog) pin_out <= !pin_out;
      end
   end

   // R5: a capture stores the time base value seen in that cycle
   p_capture_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> (cc_value == $past(tb_value)));

   // R11: a flag-setting event wins over a clear in the same cycle
   p_flag_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |=> irq);

   // R8: a match is never signalled on two clocks in a row
   p_match_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> !match);

   // R7: the output latch moves only on an enabled match
   p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tog |=> (pin_out != $past(pin_out)));
   p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !tog |=> $stable(pin_out));

   // R6: a disabled channel neither captures nor signals
   p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[3] && !wr_cc) |=> $stable(cc_value));

endmodule

// File: rtl/capcom_unit.sv
module capcom_unit
   import capcom_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int NUM_CH      = 4,
   parameter int SEL_W       = 3,
   parameter int BASE_SHIFT  = 3,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   input  logic [NUM_CH-1:0] pin_in,
   output logic [NUM_CH-1:0] pin_out,
   output logic [NUM_CH-1:0] pin_oe,
   input  logic [NUM_CH-1:0] irq_clr,
   output logic [NUM_CH-1:0] irq_flag
);
   localparam int MODE_BITS = NUM_CH * MODE_W;

   if (NUM_CH < 1 || MODE_BITS > CNT_W) begin : g_bad_ch
      $error("capcom_unit: mode word does not fit the data width");
   end
   if (ADDR_CHAN + NUM_CH > (1 << ADDR_W)) begin : g_bad_addr
      $error("capcom_unit: address width too small for the channel count");
   end
   if (SEL_W + 1 > CNT_W) begin : g_bad_ctrl
      $error("capcom_unit: control word does not fit the data width");
   end

   logic                 run;
   logic [SEL_W-1:0]     rate_sel;
   logic [MODE_BITS-1:0] mode_word;
   logic                 tick, stepped;
   logic [CNT_W-1:0]     tb_value, reload;
   logic [CNT_W-1:0]     cc_value [NUM_CH];
   logic [NUM_CH-1:0]    wr_cc;
   logic                 wr_ctrl, wr_mode, wr_time, wr_reload;

   assign wr_ctrl   = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
   assign wr_reload = wr_en && (wr_addr == ADDR_W'(ADDR_RELD));
   assign wr_time   = wr_en && (wr_addr == ADDR_W'(ADDR_TIME));
   assign wr_mode   = wr_en && (wr_addr == ADDR_W'(ADDR_MODE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run       <= 1'b0;
         rate_sel  <= '0;
         mode_word <= '0;
      end else begin
         if (wr_ctrl) begin
            run      <= wr_data[0];
            rate_sel <= wr_data[SEL_W:1];
         end
         if (wr_mode) mode_word <= wr_data[MODE_BITS-1:0];
      end
   end

   capcom_prescaler #(.SEL_W(SEL_W), .BASE_SHIFT(BASE_SHIFT)) u_presc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .sel  (rate_sel),
      .tick (tick)
   );

   capcom_timebase #(.CNT_W(CNT_W)) u_tbase (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .wr_time  (wr_time),
      .wr_reload(wr_reload),
      .wdata    (wr_data),
      .tb_value (tb_value),
      .reload   (reload),
      .stepped  (stepped)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
      assign wr_cc[k] = wr_en && (wr_addr == ADDR_W'(ADDR_CHAN + k));

      capcom_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .mode    (mode_word[k*MODE_W +: MODE_W]),
         .tb_value(tb_value),
         .stepped (stepped),
         .pin_in  (pin_in[k]),
         .wr_cc   (wr_cc[k]),
         .wdata   (wr_data),
         .irq_clr (irq_clr[k]),
         .cc_value(cc_value[k]),
         .irq     (irq_flag[k]),
         .pin_out (pin_out[k]),
         .pin_oe  (pin_oe[k])
      );

      // R10: a channel outside compare mode never drives its pin
      p_oe_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_word[k*MODE_W+3] || !mode_word[k*MODE_W+2]) |-> !pin_oe[k]);
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(ADDR_CTRL)) rd_data = CNT_W'({rate_sel, run});
      if (rd_addr == ADDR_W'(ADDR_RELD)) rd_data = reload;
      if (rd_addr == ADDR_W'(ADDR_TIME)) rd_data = tb_value;
      if (rd_addr == ADDR_W'(ADDR_MODE)) rd_data = CNT_W'(mode_word);
      for (int k = 0; k < NUM_CH; k++) begin
         if (rd_addr == ADDR_W'(ADDR_CHAN + k)) rd_data = cc_value[k];
      end
   end

   // R3: a stopped time base that is not written keeps its value
   p_stopped_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_time) |=> $stable(tb_value));

   // R2: a register write is visible on the next read of that address
   p_reload_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reload |=> (reload == $past(wr_data)));

endmodule

// File: tb/test_capcom_unit.sv
module test_capcom_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic [3:0]  pin_in = '0;
   logic [3:0]  pin_out, pin_oe, irq_flag;
   logic [3:0]  irq_clr = '0;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 0;

   always #5 clk = !clk;
   always @(posedge clk) cyc <= cyc + 1;

   capcom_unit i_capcom_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .irq_clr(irq_clr), .irq_flag(irq_flag)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      rd_addr = a; #1; d = rd_data;
   endtask

   task automatic clr(input logic [3:0] m);
      @(negedge clk); irq_clr = m;
      @(posedge clk); #1; irq_clr = '0;
   endtask

   task automatic wait_to(input int t);
      while (cyc < t) begin @(posedge clk); #1; end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      #1_500_000;
      failures++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [15:0] d;
      int w;
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      rd(4'd2, d); chk("R1 time base", d, 16'h0);
      rd(4'd0, d); chk("R1 control", d, 16'h0);
      rd(4'd5, d); chk("R1 channel 1", d, 16'h0);
      chk("R1 flags/out/oe", {irq_flag, pin_out, pin_oe}, 12'h0);

      // R2 register map read-back
      wr(4'd1, 16'hBEEF); rd(4'd1, d); chk("R2 reload", d, 16'hBEEF);
      wr(4'd3, 16'h0BAD); rd(4'd3, d); chk("R2 mode", d, 16'h0BAD);
      wr(4'd7, 16'hC0DE); rd(4'd7, d); chk("R2 channel 3", d, 16'hC0DE);
      wr(4'd0, 16'h000A); rd(4'd0, d); chk("R2 control", d, 16'h000A);
      wr(4'd3, 16'h0000);

      // R3 rate sweep over every select value
      for (int i = 0; i < 8; i++) begin
         int p;
         p = 1 << (3 + i);
         wr(4'd0, 16'(i << 1));
         wr(4'd2, 16'h0000);
         wr(4'd0, 16'((i << 1) | 1));
         w = cyc;
         wait_to(w + p - 1); rd(4'd2, d); chk("R3 before step", d, 16'h0000);
         wait_to(w + p);     rd(4'd2, d); chk("R3 at step", d, 16'h0001);
      end
      wr(4'd0, 16'h0000);
      rd(4'd2, d);
      begin
         logic [15:0] held;
         held = d;
         step(40); rd(4'd2, d); chk("R3 hold while stopped", d, held);
      end

      // R4 wrap to reload
      wr(4'd1, 16'hFFF0);
      wr(4'd2, 16'hFFFE);
      wr(4'd0, 16'h0001);
      w = cyc;
      wait_to(w + 8);  rd(4'd2, d); chk("R4 reach top", d, 16'hFFFF);
      wait_to(w + 16); rd(4'd2, d); chk("R4 reload on wrap", d, 16'hFFF0);
      wait_to(w + 24); rd(4'd2, d); chk("R4 step after wrap", d, 16'hFFF1);
      wr(4'd0, 16'h0000);

      // R7 R8 R9 R10 compare with different action bits
      wr(4'd2, 16'h0100);
      wr(4'd4, 16'h0103); wr(4'd5, 16'h0103); wr(4'd6, 16'h0103);
      wr(4'd3, 16'h1657);
      clr(4'hF);
      chk("R10 oe per mode", pin_oe, 4'b0111);
      wr(4'd0, 16'h0001);
      w = cyc;
      wait_to(w + 24);
      rd(4'd2, d); chk("R7 time at match value", d, 16'h0103);
      chk("R7 flags before action", irq_flag, 4'b0000);
      wait_to(w + 25);
      chk("R7 flags by irq bit", irq_flag, 4'b0011);
      chk("R7 toggles by toggle bit", pin_out, 4'b0101);
      clr(4'b0011);
      wait_to(w + 31);
      rd(4'd2, d); chk("R8 value still held", d, 16'h0103);
      chk("R8 no second flag", irq_flag, 4'b0000);
      chk("R8 no second toggle", pin_out, 4'b0101);
      wr(4'd4, 16'h0106);
      wait_to(w + 48);
      chk("R9 no action before new value", irq_flag[0], 1'b0);
      wait_to(w + 49);
      chk("R9 flag at new value", irq_flag[0], 1'b1);
      chk("R9 toggle at new value", pin_out[0], 1'b0);
      wr(4'd0, 16'h0000);

      // R5 R6 capture: ch0 rising, ch1 falling, ch2 both, ch3 off
      wr(4'd2, 16'h1234);
      for (int k = 0; k < 4; k++) wr(4'(4 + k), 16'hAAAA);
      wr(4'd3, 16'h0321);
      clr(4'hF);
      chk("R10 oe off in capture", pin_oe, 4'b0000);
      @(negedge clk); pin_in = 4'hF;
      step(2);
      rd(4'd4, d); chk("R5 not yet captured", d, 16'hAAAA);
      step(1);
      rd(4'd4, d); chk("R5 rising captured", d, 16'h1234);
      rd(4'd5, d); chk("R6 falling-only ignores rise", d, 16'hAAAA);
      rd(4'd6, d); chk("R5 both-edges rise", d, 16'h1234);
      rd(4'd7, d); chk("R6 off channel ignores rise", d, 16'hAAAA);
      chk("R5 capture flags rise", irq_flag, 4'b0101);
      wr(4'd2, 16'h2345);
      clr(4'hF);
      chk("R11 clear drops flags", irq_flag, 4'b0000);
      @(negedge clk); pin_in = 4'h0;
      step(3);
      rd(4'd4, d); chk("R6 rising-only ignores fall", d, 16'h1234);
      rd(4'd5, d); chk("R5 falling captured", d, 16'h2345);
      rd(4'd6, d); chk("R5 both-edges fall", d, 16'h2345);
      chk("R5 capture flags fall", irq_flag, 4'b0110);

      // R11 capture, register write and clear on the same edge
      wr(4'd2, 16'h5555);
      clr(4'hF);
      @(negedge clk); pin_in[0] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd4; wr_data = 16'h0F0F; irq_clr = 4'b0001;
      @(posedge clk); #1;
      wr_en = 1'b0; irq_clr = '0;
      rd(4'd4, d); chk("R11 capture beats write", d, 16'h5555);
      chk("R11 set beats clear", irq_flag[0], 1'b1);
      wr(4'd4, 16'h0F0F); rd(4'd4, d); chk("R11 write alone accepted", d, 16'h0F0F);

      // R6 R10 disabled channel (nibble 1011)
      wr(4'd3, 16'h000B);
      clr(4'hF);
      chk("R10 oe off when disabled", pin_oe[0], 1'b0);
      @(negedge clk); pin_in[0] = 1'b0;
      step(4);
      rd(4'd4, d); chk("R6 disabled no capture", d, 16'h0F0F);
      chk("R6 disabled no flag", irq_flag[0], 1'b0);

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule